// File: doc/BRIEF.md
# Byte-Lane I/O Port Interface

This block is the peripheral side of a 16-bit processor I/O bus whose address and data have already been separated. It holds a small bank of byte-wide ports at consecutive addresses, starting at an even base address. Each port has an output latch that drives a set of output pins and an input sample register that captures a set of input pins. A bus cycle names one 16-bit I/O address and carries an active-low byte-high-enable. Together with address bit 0, that enable picks the lanes of the 16-bit data bus that take part in the transfer.

Address bit 0 alone selects the low lane (bits 7:0) for even ports. The byte-high-enable selects the high lane (bits 15:8) for odd ports. When both are active, an even address and its odd neighbour act as one word port and move all 16 bits in one cycle. The block answers only when the I/O qualifier marks the cycle as an I/O access, so memory cycles that share the same address lines leave it untouched. Strobes are sampled on the system clock. A write latches on every edge where the write strobe is low. A read captures the input pins at the first edge of its strobe and presents them from the following cycle until the strobe ends.

Top module: `io_lane_ports`

## Requirements
- R1: During and right after reset, every output latch and every input sample register is zero, `rdata` is zero and `rlane_en` is 2'b00.
- R2: The block acts only when `io_cycle` is 1 and `io_addr` lies in BASE_ADDR to BASE_ADDR+2*NUM_PAIRS-1. Otherwise no latch changes and `rlane_en` stays 2'b00.
- R3: With `io_addr[0]`=0 and `bhe_n`=1, only the byte port at `io_addr` is accessed, on data bits 7:0.
- R4: With `io_addr[0]`=1 and `bhe_n`=0, only the odd byte port at `io_addr` is accessed, on data bits 15:8. Bits 7:0 are never driven.
- R5: With `io_addr[0]`=0 and `bhe_n`=0, the ports at `io_addr` (bits 7:0) and `io_addr`+1 (bits 15:8) move together in one cycle.
- R6: With `io_addr[0]`=1 and `bhe_n`=1, no lane is selected. The cycle changes no latch and drives no lane.
- R7: At each clock edge where `wr_n` is 0, each selected byte port latches its lane of `wdata`. Port k (address BASE_ADDR+k) appears on `pin_out[8k+7:8k]`. Without a write, `pin_out` holds its value.
- R8: A read captures the selected ports' `pin_in` bytes (port k on `pin_in[8k+7:8k]`) at the first clock edge of the read strobe. Pin changes later in the same strobe do not alter `rdata`.
- R9: From the cycle after the first edge of a read strobe until the strobe ends, `rlane_en` shows the selected lanes (bit 0 low lane, bit 1 high lane) and `rdata` carries the samples. Bits of any unselected lane are zero. With no read active, `rdata` is zero.
- R10: If `wr_n` and `rd_n` are both 0, the write is carried out and the read is suppressed: there is no sample and `rlane_en` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | Latched I/O address of the current bus cycle |
| bhe_n | input | 1 | Byte-high-enable, active low, enables data bits 15:8 |
| io_cycle | input | 1 | 1 marks an I/O cycle, 0 marks a memory cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data on `wdata` is valid while it is low |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Read data to the bus; unselected lanes are zero |
| rlane_en | output | 2 | Lane drive enables for the bus: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| pin_in | input | 8*NUM_BYTES (32) | Input pins, port k on bits 8k+7:8k |
| pin_out | output | 8*NUM_BYTES (32) | Output latch pins, port k on bits 8k+7:8k |

## Verification
A write strobe and a read strobe can be low in the same cycle, and the block then has to choose between latching and sampling. The bench provokes this by pulling both strobes low on a word access to the upper port pair. It then checks that both output latches took the new bytes while `rlane_en` stayed at zero. A second overlap occurs inside a single read, where the pin sample and a pin change can fall close together. The bench changes the pins after the first strobe edge and checks that `rdata` still shows the value captured at that edge.

// File: rtl/io_lane_pkg.sv
// Package: shared types for the byte-lane I/O port bank.
// Assumes: a 16-bit data bus split into two byte lanes.
package io_lane_pkg;

    localparam int unsigned LANES = 2;

    typedef logic [7:0] byte_t;

    // Lane selection produced by the address decoder.
    typedef struct packed {
        logic hi;   // data bits 15:8 take part
        logic lo;   // data bits 7:0 take part
    } lane_sel_t;

endpackage

// File: rtl/io_lane_decode.sv
// Module: io_lane_decode
// Matches an I/O address against the port bank and derives the byte lanes
// from address bit 0 and the active-low byte-high-enable.
// Assumes: BASE_ADDR is even; io_cycle stays stable for the whole bus cycle.
module io_lane_decode
    import io_lane_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0040,
    parameter int unsigned NUM_PAIRS = 2,
    parameter int unsigned PAIR_W    = 1
) (
    input  logic [15:0]       io_addr,
    input  logic              bhe_n,
    input  logic              io_cycle,
    output lane_sel_t         sel,
    output logic [PAIR_W-1:0] pair
);

    localparam logic [14:0] BASE_PAIR = BASE_ADDR[15:1];
    localparam logic [14:0] PAIR_CNT  = 15'(NUM_PAIRS);

    logic [14:0] offset;
    logic        hit;

    // Word-pair offset from the base and the in-range test.
    always_comb begin
        offset = io_addr[15:1] - BASE_PAIR;
        hit    = io_cycle && (offset < PAIR_CNT);
        pair   = offset[PAIR_W-1:0];
    end

    // Lane steering: bit 0 low opens the low lane, bhe_n low opens the high lane.
    always_comb begin
        sel.lo = hit && !io_addr[0];
        sel.hi = hit && !bhe_n;
    end

endmodule

// File: rtl/io_lane_strobe.sv
// Module: io_lane_strobe
// Turns the raw bus strobes into the internal write enable, the read start
// pulse and the read drive window. A write takes priority over a read.
// Assumes: strobes are synchronous to clk, or synchronised before this block.
module io_lane_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_act,
    output logic rd_start,
    output logic rd_drive
);

    logic rd_act;
    logic rd_prev;

    // Active strobe levels; a read that overlaps a write is dropped.
    always_comb begin
        wr_act = !wr_n;
        rd_act = !rd_n && wr_n;
    end

    // Remember whether the read was active at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
        end
    end

    // First edge of a read samples; later cycles drive the bus.
    always_comb begin
        rd_start = rd_act && !rd_prev;
        rd_drive = rd_act && rd_prev;
    end

endmodule

// File: rtl/io_lane_byte_port.sv
// Module: io_lane_byte_port
// One byte-wide port: an output latch written from the bus and an input
// sample register loaded from the pins.
// Assumes: the enables are already qualified by decode and strobe logic.
module io_lane_byte_port
    import io_lane_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_byte,
    input  logic  smp_en,
    input  byte_t pin_byte,
    output byte_t out_byte,
    output byte_t in_byte
);

    // Output latch: loads the bus lane while the write is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
        end else if (wr_en) begin
            out_byte <= wr_byte;
        end
    end

    // Input sample: captures the pins at the start of a selected read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_byte <= '0;
        end else if (smp_en) begin
            in_byte <= pin_byte;
        end
    end

endmodule

// File: rtl/io_lane_ports.sv
// Module: io_lane_ports (top)
// Bank of 2*NUM_PAIRS byte ports at BASE_ADDR upwards on a 16-bit I/O bus.
// Even ports use data bits 7:0 and odd ports use bits 15:8; an even/odd pair
// moves as one word when both lanes are enabled.
// Assumes: demultiplexed, latched address; BASE_ADDR even; synchronous strobes.
module io_lane_ports
    import io_lane_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0040,
    parameter int unsigned NUM_PAIRS = 2,
    localparam int unsigned NUM_BYTES = 2 * NUM_PAIRS,
    localparam int unsigned PAIR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int unsigned PIN_W     = 8 * NUM_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      io_addr,
    input  logic             bhe_n,
    input  logic             io_cycle,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata,
    output logic [1:0]       rlane_en,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out
);

    lane_sel_t         sel;
    logic [PAIR_W-1:0] pair;
    logic              wr_act;
    logic              rd_start;
    logic              rd_drive;
    byte_t             in_bytes  [NUM_PAIRS][LANES];

    io_lane_decode #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_PAIRS (NUM_PAIRS),
        .PAIR_W    (PAIR_W)
    ) u_decode (
        .io_addr  (io_addr),
        .bhe_n    (bhe_n),
        .io_cycle (io_cycle),
        .sel      (sel),
        .pair     (pair)
    );

    io_lane_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wr_act   (wr_act),
        .rd_start (rd_start),
        .rd_drive (rd_drive)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic pair_hit;

        // This pair is the one the address points at.
        always_comb pair_hit = (pair == PAIR_W'(p));

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic lane_on;
            byte_t out_byte;

            // Lane 0 follows the low-lane select, lane 1 the high-lane select.
            always_comb lane_on = pair_hit && ((l == 0) ? sel.lo : sel.hi);

            io_lane_byte_port u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_act && lane_on),
                .wr_byte  (wdata[8*l +: 8]),
                .smp_en   (rd_start && lane_on),
                .pin_byte (pin_in[8*(2*p+l) +: 8]),
                .out_byte (out_byte),
                .in_byte  (in_bytes[p][l])
            );

            // Place the latch on its own slice of the output pins.
            always_comb pin_out[8*(2*p+l) +: 8] = out_byte;
        end
    end

    // Read path: drive selected lanes in the read window, zero the rest.
    always_comb begin
        rlane_en = 2'b00;
        rdata    = '0;
        if (rd_drive) begin
            rlane_en = {sel.hi, sel.lo};
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (pair == PAIR_W'(p)) begin
                    if (sel.lo) rdata[7:0]  = in_bytes[p][0];
                    if (sel.hi) rdata[15:8] = in_bytes[p][1];
                end
            end
        end
    end

endmodule

// File: rtl/io_lane_ports_chk.sv
// Module: io_lane_ports_chk
// Checker bound to io_lane_ports; relates the bus qualifiers and strobes to
// the lane drive and the output latches.
module io_lane_ports_chk #(
    parameter int unsigned PIN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      io_addr,
    input logic             bhe_n,
    input logic             io_cycle,
    input logic             rd_n,
    input logic             wr_n,
    input logic [15:0]      rdata,
    input logic [1:0]       rlane_en,
    input logic [PIN_W-1:0] pin_out
);

    AST_MEM_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_cycle |-> rlane_en == 2'b00); // R2

    AST_MEM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_cycle |=> $stable(pin_out)); // R2

    AST_ODD_NO_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        io_addr[0] |-> !rlane_en[0]); // R4

    AST_NO_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[0] && bhe_n) |-> rlane_en == 2'b00); // R6

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(pin_out)); // R7

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (rlane_en == 2'b00 && rdata == 16'h0000)); // R9

    AST_LOW_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !rlane_en[0] |-> rdata[7:0] == 8'h00); // R9

    AST_HIGH_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !rlane_en[1] |-> rdata[15:8] == 8'h00); // R9

    AST_WRITE_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> rlane_en == 2'b00); // R10

endmodule

bind io_lane_ports io_lane_ports_chk #(.PIN_W(PIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .bhe_n    (bhe_n),
    .io_cycle (io_cycle),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rdata    (rdata),
    .rlane_en (rlane_en),
    .pin_out  (pin_out)
);

// File: tb/io_lane_ports_tb.sv
`timescale 1ns/1ps
module io_lane_ports_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        bhe_n = 1'b1;
    logic        io_cycle = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  rlane_en;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_out = '0;

    always #4 clk = ~clk;

    io_lane_ports #(.BASE_ADDR(16'h0040), .NUM_PAIRS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .bhe_n(bhe_n),
        .io_cycle(io_cycle), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .rlane_en(rlane_en), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_n = 1'b1; rd_n = 1'b1; io_cycle = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    // Single-edge write, then compare the pins with the model.
    task automatic do_write(input string req, input logic io, input logic [15:0] a,
                            input logic bh, input logic [15:0] d);
        io_addr = a; bhe_n = bh; io_cycle = io; wdata = d; wr_n = 1'b0;
        @(posedge clk); @(negedge clk);
        wr_n = 1'b1;
        chk(req, pin_out, exp_out);
        idle();
    endtask

    // Read: check data after the first edge, then change pins and check it holds.
    task automatic do_read(input string req, input logic io, input logic [15:0] a,
                           input logic bh, input logic [31:0] pins,
                           input logic [15:0] exp_d, input logic [1:0] exp_en);
        io_addr = a; bhe_n = bh; io_cycle = io; pin_in = pins; rd_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({req, " rdata"}, {16'h0, rdata}, {16'h0, exp_d});
        chk({req, " lanes"}, {30'h0, rlane_en}, {30'h0, exp_en});
        pin_in = ~pins;
        @(posedge clk); @(negedge clk);
        chk({req, " R8 hold"}, {16'h0, rdata}, {16'h0, exp_d});
        idle();
    endtask

    task automatic t_reset();
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 rdata", {16'h0, rdata}, 32'h0);
        chk("R1 lanes", {30'h0, rlane_en}, 32'h0);
    endtask

    task automatic t_writes();
        exp_out[23:16] = 8'h5A;
        do_write("R3 R7 even byte write", 1'b1, 16'h0042, 1'b1, 16'hA55A);
        exp_out[15:8] = 8'h3C;
        do_write("R4 odd byte write", 1'b1, 16'h0041, 1'b0, 16'h3C99);
        exp_out[15:0] = 16'hBEEF;
        do_write("R5 word write", 1'b1, 16'h0040, 1'b0, 16'hBEEF);
        do_write("R6 odd no-enable write", 1'b1, 16'h0043, 1'b1, 16'h1111);
        do_write("R2 memory cycle write", 1'b0, 16'h0040, 1'b0, 16'h2222);
        do_write("R2 above range write", 1'b1, 16'h0044, 1'b0, 16'h3333);
        do_write("R2 below range write", 1'b1, 16'h003E, 1'b0, 16'h4444);
    endtask

    task automatic t_reads();
        do_read("R3 R9 even byte read", 1'b1, 16'h0042, 1'b1, 32'h00770000, 16'h0077, 2'b01);
        do_read("R4 R9 odd byte read", 1'b1, 16'h0043, 1'b0, 32'hC3000000, 16'hC300, 2'b10);
        do_read("R5 word read", 1'b1, 16'h0040, 1'b0, 32'h00003412, 16'h3412, 2'b11);
        do_read("R6 odd no-enable read", 1'b1, 16'h0041, 1'b1, 32'h5555AAAA, 16'h0000, 2'b00);
        do_read("R2 memory cycle read", 1'b0, 16'h0040, 1'b0, 32'h12345678, 16'h0000, 2'b00);
    endtask

    // Both strobes low: write lands, read stays quiet.
    task automatic t_overlap();
        io_addr = 16'h0042; bhe_n = 1'b0; io_cycle = 1'b1; wdata = 16'h6655;
        pin_in = 32'hFFFFFFFF; wr_n = 1'b0; rd_n = 1'b0;
        exp_out[31:16] = 16'h6655;
        @(posedge clk); @(negedge clk);
        chk("R10 lanes during overlap", {30'h0, rlane_en}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R10 lanes still quiet", {30'h0, rlane_en}, 32'h0);
        chk("R10 write applied", pin_out, exp_out);
        idle();
        chk("R9 idle rdata", {16'h0, rdata}, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_writes();
        t_reads();
        t_overlap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule